// File: doc/BRIEF.md
# Memory-Operand Micro-Op Cracker

This block sits between instruction decode and the micro-op queue. Each decoded instruction arrives with a three-bit operand-form code. The block breaks the instruction into the unfused micro-ops that the scheduler and execution units consume.

A register-only instruction leaves as a single ALU micro-op. A plain load move or store move leaves as a single memory micro-op. A read-modify instruction becomes a load into a temporary register, followed by an ALU operation that reads that temporary. A read-modify-write instruction becomes four micro-ops: load, ALU, store-address and store-data.

The reorder-buffer allocator counts entries differently from the scheduler. Each micro-op therefore carries two flags: one closes a fused group and one closes the instruction. A separate field gives the number of fused groups in the instruction, so the allocator can charge one entry per group. Both edges of the block use a valid/ready handshake. Micro-ops leave strictly in order, at most one per cycle.

Top module: `mem_uop_cracker`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: Form code 0 (register-only) and the unused form codes 5, 6 and 7 each produce one micro-op. That micro-op has kind ALU (0), dst = in_dst, srca = in_dst and srcb = in_src. Both of its flags are set and the group count is 1.
- R3: Form code 1 (load move) produces one micro-op of kind LD (1), with dst = in_dst, srca = in_base and srcb = 0. Form code 2 (store move) produces one micro-op of kind ST (2), with dst = 0, srca = in_base and srcb = in_src. In both cases both flags are set and the group count is 1.
- R4: Form code 3 (read-modify) produces two micro-ops. The first has kind LD, dst = TMP_TAG, srca = in_base and srcb = 0, with both flags clear. The second has kind ALU, dst = in_dst, srca = in_dst and srcb = TMP_TAG, with both flags set. The group count is 1.
- R5: Form code 4 (read-modify-write) produces four micro-ops, in this order:
  - LD with dst = TMP_TAG and srca = in_base.
  - ALU with dst = TMP_TAG, srca = TMP_TAG and srcb = in_src; this one closes the first group.
  - STA (3) with srca = in_base.
  - STD (4) with srcb = TMP_TAG; this one closes the second group and the instruction.

  All other register fields are 0. The group count is 2.
- R6: The micro-ops of one instruction leave in order, one per accepted cycle. in_ready stays low while any micro-op other than the last is pending. in_ready is high in the cycle the last micro-op is accepted, so the next instruction's first micro-op follows with no idle cycle.
- R7: While out_valid is high and out_ready is low, every output field holds its value. No micro-op is repeated or skipped.
- R8: Every micro-op carries the instruction's in_op value on out_op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle if valid |
| in_form | input | 3 | Operand-form code |
| in_op | input | OP_W | Operation code |
| in_dst | input | REG_W | Destination / register operand |
| in_src | input | REG_W | Second register operand |
| in_base | input | REG_W | Address base register |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Queue accepts micro-op |
| out_kind | output | 3 | Micro-op kind (ALU, LD, ST, STA, STD) |
| out_dst | output | REG_W | Destination tag |
| out_srca | output | REG_W | First source tag |
| out_srcb | output | REG_W | Second source tag |
| out_op | output | OP_W | Operation code |
| out_grp_end | output | 1 | Last micro-op of a fused group |
| out_ins_end | output | 1 | Last micro-op of the instruction |
| out_grp_cnt | output | 2 | Fused groups in the current instruction |

## Verification
An instruction accepted at one rising edge shows its first micro-op after that edge. Each later micro-op appears one edge after the previous one is taken. The bench drives inputs on falling edges and samples every micro-op on the falling edge that follows the edge where it becomes due. After the last micro-op it checks one more falling edge to confirm the output has gone idle. The overlap test confirms that the next instruction's first micro-op arrives exactly one edge after the last micro-op of the previous one. The back-pressure test holds out_ready low over several falling edges and confirms that the same micro-op, with identical fields, is still present at each one.

// File: rtl/uop_crack_pkg.sv
package uop_crack_pkg;

    parameter int unsigned REG_W = 5;
    parameter int unsigned OP_W  = 4;

    localparam logic [2:0] FORM_REG   = 3'd0;
    localparam logic [2:0] FORM_LDMOV = 3'd1;
    localparam logic [2:0] FORM_STMOV = 3'd2;
    localparam logic [2:0] FORM_RDMOD = 3'd3;
    localparam logic [2:0] FORM_RMW   = 3'd4;

    typedef logic [REG_W-1:0] rtag_t;

    typedef enum logic [2:0] {
        UK_ALU = 3'd0,
        UK_LD  = 3'd1,
        UK_ST  = 3'd2,
        UK_STA = 3'd3,
        UK_STD = 3'd4
    } ukind_e;

    typedef struct packed {
        logic [2:0]      form;
        logic [OP_W-1:0] op;
        rtag_t           dst;
        rtag_t           src;
        rtag_t           base;
    } insn_t;

    typedef struct packed {
        ukind_e          kind;
        rtag_t           dst;
        rtag_t           srca;
        rtag_t           srcb;
        logic [OP_W-1:0] op;
        logic            grp_end;
        logic            ins_end;
    } uop_t;

    // Index of the final micro-op for a form
    function automatic logic [1:0] last_step(input logic [2:0] form);
        case (form)
            FORM_RDMOD: last_step = 2'd1;
            FORM_RMW:   last_step = 2'd3;
            default:    last_step = 2'd0;
        endcase
    endfunction

    // Number of fused groups (reorder-buffer entries) for a form
    function automatic logic [1:0] group_total(input logic [2:0] form);
        group_total = (form == FORM_RMW) ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/uop_crack_hold.sv
module uop_crack_hold
    import uop_crack_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  insn_t insn_in,
    output insn_t insn_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            insn_q <= '0;
        end else if (load_en) begin
            insn_q <= insn_in;
        end
    end

endmodule

// File: rtl/uop_crack_seq.sv
module uop_crack_seq (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       out_ready,
    input  logic [1:0] last_idx,
    output logic       in_ready,
    output logic       out_valid,
    output logic       load_en,
    output logic [1:0] step
);

    logic busy;
    logic fire;
    logic at_last;

    assign fire      = busy && out_ready;
    assign at_last   = (step == last_idx);
    assign in_ready  = !busy || (fire && at_last);
    assign load_en   = in_valid && in_ready;
    assign out_valid = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            step <= 2'd0;
        end else if (load_en) begin
            busy <= 1'b1;
            step <= 2'd0;
        end else if (fire) begin
            if (at_last) begin
                busy <= 1'b0;
                step <= 2'd0;
            end else begin
                step <= step + 2'd1;
            end
        end
    end

endmodule

// File: rtl/uop_crack_gen.sv
module uop_crack_gen
    import uop_crack_pkg::*;
#(
    parameter rtag_t TMP_TAG = rtag_t'(31)
) (
    input  insn_t      insn,
    input  logic [1:0] step,
    output uop_t       uop
);

    always_comb begin
        uop.kind    = UK_ALU;
        uop.dst     = insn.dst;
        uop.srca    = insn.dst;
        uop.srcb    = insn.src;
        uop.op      = insn.op;
        uop.grp_end = 1'b1;
        uop.ins_end = 1'b1;
        case (insn.form)
            FORM_LDMOV: begin
                uop.kind = UK_LD;
                uop.srca = insn.base;
                uop.srcb = '0;
            end
            FORM_STMOV: begin
                uop.kind = UK_ST;
                uop.dst  = '0;
                uop.srca = insn.base;
            end
            FORM_RDMOD: begin
                if (step == 2'd0) begin
                    uop.kind    = UK_LD;
                    uop.dst     = TMP_TAG;
                    uop.srca    = insn.base;
                    uop.srcb    = '0;
                    uop.grp_end = 1'b0;
                    uop.ins_end = 1'b0;
                end else begin
                    uop.srcb = TMP_TAG;
                end
            end
            FORM_RMW: begin
                case (step)
                    2'd0: begin
                        uop.kind    = UK_LD;
                        uop.dst     = TMP_TAG;
                        uop.srca    = insn.base;
                        uop.srcb    = '0;
                        uop.grp_end = 1'b0;
                        uop.ins_end = 1'b0;
                    end
                    2'd1: begin
                        uop.dst     = TMP_TAG;
                        uop.srca    = TMP_TAG;
                        uop.ins_end = 1'b0;
                    end
                    2'd2: begin
                        uop.kind    = UK_STA;
                        uop.dst     = '0;
                        uop.srca    = insn.base;
                        uop.srcb    = '0;
                        uop.grp_end = 1'b0;
                        uop.ins_end = 1'b0;
                    end
                    default: begin
                        uop.kind = UK_STD;
                        uop.dst  = '0;
                        uop.srca = '0;
                        uop.srcb = TMP_TAG;
                    end
                endcase
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/mem_uop_cracker.sv
module mem_uop_cracker
    import uop_crack_pkg::*;
#(
    parameter rtag_t TMP_TAG = rtag_t'(31)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_form,
    input  logic [OP_W-1:0]  in_op,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src,
    input  logic [REG_W-1:0] in_base,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_kind,
    output logic [REG_W-1:0] out_dst,
    output logic [REG_W-1:0] out_srca,
    output logic [REG_W-1:0] out_srcb,
    output logic [OP_W-1:0]  out_op,
    output logic             out_grp_end,
    output logic             out_ins_end,
    output logic [1:0]       out_grp_cnt
);

    insn_t      insn_d;
    insn_t      insn_q;
    uop_t       uop;
    logic       load_en;
    logic [1:0] step;

    assign insn_d = '{form: in_form, op: in_op, dst: in_dst, src: in_src, base: in_base};

    uop_crack_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .insn_in (insn_d),
        .insn_q  (insn_q)
    );

    uop_crack_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .last_idx  (last_step(insn_q.form)),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load_en   (load_en),
        .step      (step)
    );

    uop_crack_gen #(.TMP_TAG(TMP_TAG)) u_gen (
        .insn (insn_q),
        .step (step),
        .uop  (uop)
    );

    assign out_kind    = uop.kind;
    assign out_dst     = uop.dst;
    assign out_srca    = uop.srca;
    assign out_srcb    = uop.srcb;
    assign out_op      = uop.op;
    assign out_grp_end = uop.grp_end;
    assign out_ins_end = uop.ins_end;
    assign out_grp_cnt = group_total(insn_q.form);

endmodule

// File: rtl/mem_uop_cracker_chk.sv
module mem_uop_cracker_chk
    import uop_crack_pkg::*;
#(
    parameter rtag_t TMP_TAG = rtag_t'(31)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [2:0]       out_kind,
    input logic [REG_W-1:0] out_dst,
    input logic [REG_W-1:0] out_srca,
    input logic [REG_W-1:0] out_srcb,
    input logic [OP_W-1:0]  out_op,
    input logic             out_grp_end,
    input logic             out_ins_end,
    input logic [1:0]       out_grp_cnt
);

    AST_IDLE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready)); // R1

    AST_LOAD_FEEDS_ALU: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_kind == 3'd1 && !out_ins_end)
        |=> (out_valid && out_kind == 3'd0 && (out_srca == TMP_TAG || out_srcb == TMP_TAG))); // R4

    AST_STA_THEN_STD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_kind == 3'd3)
        |=> (out_valid && out_kind == 3'd4 && out_ins_end && out_grp_end)); // R5

    AST_INS_CLOSES_GRP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ins_end) |-> out_grp_end); // R5

    AST_INPUT_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_ready && out_ins_end)) |-> !in_ready); // R6

    AST_NEXT_ADMIT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_ins_end) |-> in_ready); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_dst)
        && $stable(out_srca) && $stable(out_srcb) && $stable(out_op)
        && $stable(out_grp_end) && $stable(out_ins_end) && $stable(out_grp_cnt))); // R7

endmodule

bind mem_uop_cracker mem_uop_cracker_chk #(.TMP_TAG(TMP_TAG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_kind    (out_kind),
    .out_dst     (out_dst),
    .out_srca    (out_srca),
    .out_srcb    (out_srcb),
    .out_op      (out_op),
    .out_grp_end (out_grp_end),
    .out_ins_end (out_ins_end),
    .out_grp_cnt (out_grp_cnt)
);

// File: tb/mem_uop_cracker_test.sv
module mem_uop_cracker_test;

    localparam logic [4:0] TMP = 5'd31;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] in_form = '0;
    logic [3:0] in_op = '0;
    logic [4:0] in_dst = '0, in_src = '0, in_base = '0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [2:0] out_kind;
    logic [4:0] out_dst, out_srca, out_srcb;
    logic [3:0] out_op;
    logic       out_grp_end, out_ins_end;
    logic [1:0] out_grp_cnt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mem_uop_cracker uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_form(in_form), .in_op(in_op), .in_dst(in_dst), .in_src(in_src), .in_base(in_base),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_dst(out_dst), .out_srca(out_srca), .out_srcb(out_srcb),
        .out_op(out_op), .out_grp_end(out_grp_end), .out_ins_end(out_ins_end),
        .out_grp_cnt(out_grp_cnt)
    );

    // {uops[2:0], groups[1:0], form[2:0], op[3:0], dst, src, base}
    localparam logic [26:0] VEC [8] = '{
        {3'd1, 2'd1, 3'd0, 4'd3,  5'd1,  5'd2,  5'd3},
        {3'd1, 2'd1, 3'd1, 4'd0,  5'd4,  5'd0,  5'd5},
        {3'd1, 2'd1, 3'd2, 4'd0,  5'd0,  5'd6,  5'd7},
        {3'd2, 2'd1, 3'd3, 4'd5,  5'd8,  5'd0,  5'd9},
        {3'd4, 2'd2, 3'd4, 4'd2,  5'd0,  5'd10, 5'd11},
        {3'd4, 2'd2, 3'd4, 4'd15, 5'd0,  5'd30, 5'd1},
        {3'd2, 2'd1, 3'd3, 4'd1,  5'd12, 5'd0,  5'd13},
        {3'd1, 2'd1, 3'd6, 4'd7,  5'd14, 5'd15, 5'd16}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] f);
        case (f)
            3'd1, 3'd2: req_of = "R3";
            3'd3:       req_of = "R4";
            3'd4:       req_of = "R5";
            default:    req_of = "R2";
        endcase
    endfunction

    // Expected micro-op word {kind, dst, srca, srcb, op, grp_end, ins_end}, from the requirements
    function automatic logic [31:0] exp_uop(input logic [21:0] ins, input int s);
        logic [2:0] f;
        logic [3:0] op;
        logic [4:0] d, sr, b;
        logic [2:0] k;
        logic [4:0] ed, ea, eb;
        logic ge, ie;
        {f, op, d, sr, b} = ins;
        k = 3'd0; ed = d; ea = d; eb = sr; ge = 1'b1; ie = 1'b1;
        case (f)
            3'd1: begin k = 3'd1; ea = b; eb = 5'd0; end
            3'd2: begin k = 3'd2; ed = 5'd0; ea = b; end
            3'd3: begin
                if (s == 0) begin k = 3'd1; ed = TMP; ea = b; eb = 5'd0; ge = 0; ie = 0; end
                else eb = TMP;
            end
            3'd4: begin
                case (s)
                    0: begin k = 3'd1; ed = TMP; ea = b; eb = 5'd0; ge = 0; ie = 0; end
                    1: begin ed = TMP; ea = TMP; ie = 0; end
                    2: begin k = 3'd3; ed = 5'd0; ea = b; eb = 5'd0; ge = 0; ie = 0; end
                    default: begin k = 3'd4; ed = 5'd0; ea = 5'd0; eb = TMP; end
                endcase
            end
            default: ;
        endcase
        exp_uop = {8'd0, k, ed, ea, eb, op, ge, ie};
    endfunction

    function automatic logic [31:0] act_uop();
        act_uop = {8'd0, out_kind, out_dst, out_srca, out_srcb, out_op, out_grp_end, out_ins_end};
    endfunction

    task automatic drive(input logic [21:0] ins);
        {in_form, in_op, in_dst, in_src, in_base} = ins;
        in_valid = 1'b1;
    endtask

    task automatic run_vec(input logic [26:0] v);
        logic [21:0] ins;
        int n, g;
        string r;
        ins = v[21:0];
        n = int'(v[26:24]);
        g = int'(v[23:22]);
        r = req_of(v[21:19]);
        @(negedge clk);
        chk("R6 idle ready", 32'(in_ready), 32'd1);
        drive(ins);
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk({r, " valid"}, 32'(out_valid), 32'd1);
            chk({r, " uop (R8 op)"}, act_uop(), exp_uop(ins, s));
            chk({r, " group count"}, 32'(out_grp_cnt), 32'(g));
            chk("R6 in_ready", 32'(in_ready), (s == n - 1) ? 32'd1 : 32'd0);
        end
        @(negedge clk);
        chk("R7 no extra uop", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [21:0] a, b;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 32'(out_valid), 32'd0);
        chk("R1 ready after reset", 32'(in_ready), 32'd1);

        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        // R6: back-to-back read-modify-write instructions, no gap
        a = {3'd4, 4'd9, 5'd0, 5'd3, 5'd4};
        b = {3'd4, 4'd6, 5'd0, 5'd7, 5'd8};
        @(negedge clk);
        drive(a);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            drive(b);
            chk("R6 first instr uop", act_uop(), exp_uop(a, s));
            chk("R6 stall input", 32'(in_ready), (s == 3) ? 32'd1 : 32'd0);
        end
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk("R6 second instr valid", 32'(out_valid), 32'd1);
            chk("R6 second instr uop", act_uop(), exp_uop(b, s));
        end
        @(negedge clk);
        chk("R6 drained", 32'(out_valid), 32'd0);

        // R7: back-pressure on first and last micro-op of a read-modify
        a = {3'd3, 4'd4, 5'd2, 5'd0, 5'd5};
        @(negedge clk);
        out_ready = 1'b0;
        drive(a);
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk("R7 held uop0", act_uop(), exp_uop(a, 0));
            chk("R7 held valid", 32'(out_valid), 32'd1);
            chk("R6 stall under hold", 32'(in_ready), 32'd0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            chk("R7 held uop1", act_uop(), exp_uop(a, 1));
            chk("R6 last held, no admit", 32'(in_ready), 32'd0);
        end
        out_ready = 1'b1;
        #0;
        chk("R6 admit on last accept", 32'(in_ready), 32'd1);
        @(negedge clk);
        chk("R7 single delivery", 32'(out_valid), 32'd0);

        // R1: reset mid-instruction clears output
        drive({3'd4, 4'd1, 5'd0, 5'd1, 5'd2});
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset clears valid", 32'(out_valid), 32'd0);
        chk("R1 reset ready", 32'(in_ready), 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule